// File: doc/BRIEF.md
# Mains-Locked Equal-Pulse Gate Generator for a Three-Phase AC Chopper

This block drives the six gates of a three-phase AC buck chopper built from bidirectional switches. Each phase has a pair of switches. One switch of each pair conducts for the whole positive half cycle of its phase, as reported by a zero-crossing comparator. The other switch chops the negative half cycle with a common equal-width PWM stream. The PWM comes from a digital sawtooth carrier whose frequency is locked to the mains, so every half cycle holds the same number of equal pulses. That pulse count sets which current harmonics remain.

Software-style controls are plain level inputs: a 2-bit pulse-count select and an 8-bit duty word. Both are sampled only at carrier boundaries. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. The three zero-crossing inputs are asynchronous to the clock and are synchronised inside the block. The carrier restarts on every rising zero crossing of phase A, which keeps the pulses aligned to the half cycle.

Top module: `egp_gate_gen`

## Requirements
- R1: After reset all six gates stay low, whatever the other inputs are, until the first rising edge of the synchronised phase-A zero-crossing input has been seen; from then on the gates follow R3 and R4.
- R2: Each zero-crossing input passes through two synchronising flops, so a change on `zcd_i` reaches the directly driven gate after exactly two rising clock edges.
- R3: `gate_o[2k]` (k = 0 for phase A, 1 for B, 2 for C; bit k of `zcd_i`) equals the synchronised zero-crossing level of phase k.
- R4: `gate_o[2k+1]` equals the inverted synchronised zero-crossing level of phase k ANDed with the common PWM stream.
- R5: The pulse count is P = 36 + 6·`psel_i` (00→36, 01→42, 10→48, 11→54). The carrier steps through 256 values, each lasting D clocks, where D = floor(CLK_HZ / (2·P·MAINS_HZ·256)), and D is at least 1. One carrier period is therefore 256·D clocks.
- R6: The PWM is high while the 8-bit carrier value is below the active duty word d, which gives d·D high clocks per period for d in 1..254.
- R7: A duty word of 0 keeps the PWM low for the whole period. A duty word of 255 keeps it high for the whole period.
- R8: A rising edge of the synchronised phase-A input restarts the carrier at value 0 in the following clock. The PWM is therefore high for the first d·D clocks after the restart and low in the clock after that.
- R9: A new `psel_i` or `duty_i` value takes effect only at a carrier wrap or at a phase-A restart. A change in the middle of a period leaves that period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| psel_i | input | 2 | Pulse-count select (see R5) |
| duty_i | input | 8 | Duty word compared with the carrier |
| zcd_i | input | 3 | Zero-crossing levels; bit 0 is A, bit 1 is B, bit 2 is C; high in the positive half cycle |
| gate_o | output | 6 | Gate drives; bits 0/2/4 are the direct switches, bits 1/3/5 the chopped switches |

## Verification
A wrong carrier state shows up as a wrong count of chopped-gate high clocks over one 256·D window. A corrupted prescaler or a bad duty latch is therefore visible within one carrier period. A lost or spurious restart moves the pulse boundary relative to the phase-A edge, and this can be seen in the first d·D+1 clocks after the edge. A synchroniser of the wrong depth moves the direct gate by a clock within two edges of an input change. A wrongly set arming flag makes the gates move before the first phase-A edge.

// File: rtl/egp_pkg.sv
package egp_pkg;
  localparam int CAR_W   = 8;
  localparam int NUM_PH  = 3;
  localparam int NUM_SEL = 4;

  // pulses per half cycle for a select code
  function automatic int egp_pulses(input int sel);
    return 36 + 6 * sel;
  endfunction

  // clocks per carrier step, floor, never below one
  function automatic int egp_div(input int clk_hz, input int mains_hz, input int sel);
    longint d;
    d = longint'(clk_hz) / (longint'(2) * egp_pulses(sel) * mains_hz * (1 << CAR_W));
    if (d < 1) d = 1;
    return int'(d);
  endfunction
endpackage

// File: rtl/egp_sync.sv
module egp_sync #(
  parameter int NUM_PH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_PH-1:0] async_i,
  output logic [NUM_PH-1:0] sync_o,
  output logic              rise_a_o
);
  logic [NUM_PH-1:0] stg_q [SYNC_STAGES];
  logic              last_a_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
      last_a_q <= 1'b0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      last_a_q <= stg_q[SYNC_STAGES-1][0];
    end
  end

  assign sync_o   = stg_q[SYNC_STAGES-1];
  assign rise_a_o = sync_o[0] & ~last_a_q;
endmodule

// File: rtl/egp_carrier.sv
module egp_carrier
  import egp_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int MAINS_HZ = 50,
  parameter int DIV_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [1:0]       psel_i,
  input  logic [CAR_W-1:0] duty_i,
  output logic [CAR_W-1:0] carrier_o,
  output logic [CAR_W-1:0] duty_o
);
  localparam logic [CAR_W-1:0] CAR_MAX = '1;

  logic [DIV_W-1:0] div_tbl [NUM_SEL];
  logic [DIV_W-1:0] pre_q;
  logic [CAR_W-1:0] car_q;
  logic [CAR_W-1:0] duty_q;
  logic [1:0]       psel_q;
  logic             tick, wrap;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_div
    assign div_tbl[g] = DIV_W'(egp_div(CLK_HZ, MAINS_HZ, g));
  end

  assign tick = (pre_q == div_tbl[psel_q] - DIV_W'(1));
  assign wrap = tick && (car_q == CAR_MAX);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q  <= '0;
      car_q  <= '0;
      duty_q <= '0;
      psel_q <= '0;
    end else if (restart_i) begin
      pre_q  <= '0;
      car_q  <= '0;
      duty_q <= duty_i;
      psel_q <= psel_i;
    end else if (tick) begin
      pre_q <= '0;
      car_q <= car_q + CAR_W'(1);
      if (wrap) begin
        duty_q <= duty_i;
        psel_q <= psel_i;
      end
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end

  assign carrier_o = car_q;
  assign duty_o    = duty_q;

  assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (car_q == '0 && pre_q == '0));
  assert_carrier_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && !restart_i) |=> (car_q == CAR_W'($past(car_q) + 1)));
  assert_hold_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick && !restart_i) |=> $stable(car_q));
  assert_prescale_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    pre_q < div_tbl[psel_q]);
  assert_no_midperiod_change_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(restart_i || wrap) |=> ($stable(duty_q) && $stable(psel_q)));
endmodule

// File: rtl/egp_pwm_cmp.sv
module egp_pwm_cmp
  import egp_pkg::*;
(
  input  logic [CAR_W-1:0] carrier_i,
  input  logic [CAR_W-1:0] duty_i,
  output logic             pwm_o
);
  localparam logic [CAR_W-1:0] FULL = '1;
  // the top code forces a full-period high level
  assign pwm_o = (duty_i == FULL) || (carrier_i < duty_i);
endmodule

// File: rtl/egp_gate_map.sv
module egp_gate_map
  import egp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              armed_i,
  input  logic              pwm_i,
  input  logic [CAR_W-1:0]  duty_i,
  input  logic [NUM_PH-1:0] zsync_i,
  output logic [2*NUM_PH-1:0] gate_o
);
  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    assign gate_o[2*k]   = armed_i & zsync_i[k];
    assign gate_o[2*k+1] = armed_i & ~zsync_i[k] & pwm_i;

    assert_zero_duty_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (duty_i == '0) |-> !gate_o[2*k+1]);
    assert_full_duty_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (duty_i == '1 && armed_i) |-> (gate_o[2*k+1] == ~zsync_i[k]));
  end
endmodule

// File: rtl/egp_gate_gen.sv
module egp_gate_gen
  import egp_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int MAINS_HZ    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] psel_i,
  input  logic [7:0] duty_i,
  input  logic [2:0] zcd_i,
  output logic [5:0] gate_o
);
  localparam int DIV_MAX = egp_div(CLK_HZ, MAINS_HZ, 0);
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic [NUM_PH-1:0] zsync;
  logic              rise_a;
  logic [CAR_W-1:0]  carrier, duty_act;
  logic              pwm;
  logic              armed_q;

  egp_sync #(.NUM_PH(NUM_PH), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(zcd_i),
    .sync_o(zsync), .rise_a_o(rise_a)
  );

  egp_carrier #(.CLK_HZ(CLK_HZ), .MAINS_HZ(MAINS_HZ), .DIV_W(DIV_W)) car_i (
    .clk_i(clk_i), .rst_i(rst_i), .restart_i(rise_a),
    .psel_i(psel_i), .duty_i(duty_i),
    .carrier_o(carrier), .duty_o(duty_act)
  );

  egp_pwm_cmp cmp_i (.carrier_i(carrier), .duty_i(duty_act), .pwm_o(pwm));

  always_ff @(posedge clk_i) begin
    if (rst_i)       armed_q <= 1'b0;
    else if (rise_a) armed_q <= 1'b1;
  end

  egp_gate_map map_i (
    .clk_i(clk_i), .rst_i(rst_i), .armed_i(armed_q), .pwm_i(pwm),
    .duty_i(duty_act), .zsync_i(zsync), .gate_o(gate_o)
  );

  assert_arm_on_edge_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_a |=> armed_q);
  assert_arm_sticky_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    armed_q |=> armed_q);
  assert_idle_before_arm_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!armed_q && !rise_a) |=> (gate_o == '0));
endmodule

// File: tb/egp_gate_gen_tb_top.sv
module egp_gate_gen_tb_top;
  localparam int CLK_HZ   = 2_764_800;
  localparam int MAINS_HZ = 50;

  logic       clk = 1'b0;
  logic       rst_i;
  logic [1:0] psel_i;
  logic [7:0] duty_i;
  logic [2:0] zcd_i;
  logic [5:0] gate_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  egp_gate_gen #(.CLK_HZ(CLK_HZ), .MAINS_HZ(MAINS_HZ)) dut_i (
    .clk_i(clk), .rst_i(rst_i), .psel_i(psel_i), .duty_i(duty_i),
    .zcd_i(zcd_i), .gate_o(gate_o)
  );

  // vector: psel[9:8], duty[7:0]
  localparam logic [9:0] VEC [7] = '{
    {2'd0, 8'd102}, {2'd1, 8'd128}, {2'd2, 8'd230}, {2'd3, 8'd179},
    {2'd0, 8'd0},   {2'd3, 8'd255}, {2'd2, 8'd1}
  };

  function automatic int div_of(input int sel);
    int p, d;
    p = 36 + 6 * sel;
    d = CLK_HZ / (2 * p * MAINS_HZ * 256);
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int high_of(input int sel, input int duty);
    if (duty == 255) return 256 * div_of(sel);
    return duty * div_of(sel);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count clocks the given gate is high over n samples
  task automatic count_high(input int bit_i, input int n, output int cnt);
    cnt = 0;
    for (int s = 0; s < n; s++) begin
      if (gate_o[bit_i]) cnt++;
      step(1);
    end
  endtask

  // lower A, set controls, raise A; returns at sample 0 after restart
  task automatic restart_with(input int sel, input int duty);
    zcd_i[0] = 1'b0;
    step(5);
    psel_i = 2'(sel);
    duty_i = 8'(duty);
    zcd_i[0] = 1'b1;
    step(3);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_i = 1'b1; psel_i = 2'd0; duty_i = 8'd255; zcd_i = 3'b110;
    step(4);
    rst_i = 1'b0;
    step(10);
    check("R1 gates idle before first A edge", int'(gate_o), 0);

    zcd_i[0] = 1'b1;
    step(2);
    check("R1 still idle before restart edge", int'(gate_o), 0);
    step(1);
    check("R1 direct gate A armed", int'(gate_o[0]), 1);
    check("R3 direct gate B", int'(gate_o[2]), 1);
    check("R4 chopped gate B off while B high", int'(gate_o[3]), 0);

    // R2: two-flop latency on phase C
    zcd_i[2] = 1'b0;
    step(1);
    check("R2 gate C unchanged after one edge", int'(gate_o[4]), 1);
    step(1);
    check("R2 gate C follows after two edges", int'(gate_o[4]), 0);
    check("R4 chopped gate C with full duty", int'(gate_o[5]), 1);

    // table walk: A high, B low, C high
    zcd_i = 3'b101;
    foreach (VEC[i]) begin
      int sel, duty, per;
      sel  = int'(VEC[i][9:8]);
      duty = int'(VEC[i][7:0]);
      per  = 256 * div_of(sel);
      restart_with(sel, duty);
      check("R8 chopped gate at restart", int'(gate_o[3]), (duty > 0) ? 1 : 0);
      check("R3 direct gates A/B/C", int'({gate_o[4], gate_o[2], gate_o[0]}), 3'b101);
      count_high(3, per, cnt);
      check("R6 R5 R7 high clocks per period", cnt, high_of(sel, duty));
      check("R4 chopped gate A off while A high", int'(gate_o[1]), 0);
    end

    // R8 alignment: boundary exactly at d*D clocks
    begin
      int hi;
      restart_with(1, 40);
      hi = high_of(1, 40);
      step(hi - 1);
      check("R8 last high clock", int'(gate_o[3]), 1);
      step(1);
      check("R8 first low clock", int'(gate_o[3]), 0);
    end

    // R4 with A low: chopped gate A carries the PWM
    zcd_i[0] = 1'b0;
    step(4);
    count_high(1, 256 * div_of(1), cnt);
    check("R4 chopped gate A high clocks", cnt, high_of(1, 40));
    check("R3 direct gate A low", int'(gate_o[0]), 0);

    // R9: change mid period, takes effect next period
    restart_with(0, 128);
    count_high(3, 10, cnt);
    begin
      int c2;
      psel_i = 2'd3; duty_i = 8'd32;
      count_high(3, 256 * div_of(0) - 10, c2);
      check("R9 period unchanged after mid change", cnt + c2, high_of(0, 128));
      count_high(3, 256 * div_of(3), c2);
      check("R9 new settings next period", c2, high_of(3, 32));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule